// File: doc/BRIEF.md
# DMA Source Address Tracker

This block keeps the source start address of one DMA channel. Software programs a 32-bit visible address register over a byte-enabled register bus. The transfer engine drives four controls: a start pulse, a per-beat step strobe, an end-of-operand pulse and an end-of-transfer pulse. At start, the visible value is copied into a private working address. Each step advances the working address by the beat size. At operand and transfer boundaries, the working address is copied back into the visible register.

Two options change what happens at a boundary. A source-mode code of 3'b011 selects rotate behaviour, which suppresses every copy-back, so the visible register keeps the address that was loaded at start. When the reload-enable input is high, the end of the whole transfer loads a separately programmed reload address into the visible register instead. Software writes are checked before they are accepted. A partial-width write is dropped with no flag. A write made during an active transfer, or one with a misaligned address, is rejected and reported by a one-cycle error pulse.

Top module: `dma_src_addr_tracker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `work_addr`, `reg_rdata`, `err_busy` and `err_align` are all zero.
- R2: A write with `wr_en`=1 and `wr_be`=4'hF, made while the channel is not active (active means `busy`=1 and `xfer_en`=1) and with an aligned address, sets `reg_rdata` to `wr_data` in the next cycle.
- R3: A write with any `wr_be` other than 4'hF is ignored. `reg_rdata` does not change, and neither error flag rises.
- R4: A full-width write while the channel is active is rejected. `reg_rdata` is unchanged, and `err_busy` is 1 for exactly the next cycle.
- R5: Alignment depends on `size32`. When `size32`=0 (16-bit beats), `wr_data[0]` must be 0. When `size32`=1 (32-bit beats), `wr_data[1:0]` must be 0. A full-width, non-active write that is misaligned is not stored, and `err_align` is 1 for exactly the next cycle. Only one error flag is ever raised for a given write.
- R6: A `start` pulse copies `reg_rdata` into `work_addr`, which shows the copy in the next cycle. If `step` is high in the same cycle, `start` wins.
- R7: Each `step` pulse without `start` adds 2 to `work_addr` when `size32`=0, or 4 when `size32`=1, modulo 2^32.
- R8: An `op_end` pulse in non-rotate mode copies the working address into `reg_rdata`. The copied value includes any step taken in that same cycle.
- R9: An `xfer_end` pulse with `reload_en`=0 in non-rotate mode makes the same copy-back as R8.
- R10: When `src_mode`=3'b011 (rotate), neither `op_end` nor `xfer_end` changes `reg_rdata`, so it keeps the value loaded at start.
- R11: An `xfer_end` pulse with `reload_en`=1 loads the reload register into `reg_rdata`, whatever the mode. This reload takes priority over a copy-back in the same cycle.
- R12: `rld_wr_en`=1 stores `rld_wr_data` in the reload register, which takes effect from the next cycle.
- R13: A boundary update (R8, R9 or R11) in the same cycle as an accepted software write wins, and the software value is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the visible address register |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rld_wr_en | input | 1 | Write strobe for the reload register |
| rld_wr_data | input | 32 | Reload register write data |
| busy | input | 1 | Channel is running a transfer |
| xfer_en | input | 1 | Transfer is enabled |
| size32 | input | 1 | Beat size: 0 = 16-bit, 1 = 32-bit |
| src_mode | input | 3 | Source address mode; 3'b011 is rotate |
| reload_en | input | 1 | Reload the visible register at transfer end |
| start | input | 1 | Transfer start pulse |
| step | input | 1 | One data beat completed |
| op_end | input | 1 | End of a single-operand transfer |
| xfer_end | input | 1 | End of the whole transfer |
| work_addr | output | 32 | Current working address |
| reg_rdata | output | 32 | Readback of the visible address register |
| err_busy | output | 1 | One-cycle pulse: write rejected because the channel is active |
| err_align | output | 1 | One-cycle pulse: write rejected because it is misaligned |

## Verification
The bench sweeps every beat size, all eight mode codes and both reload settings through a full start, step, operand-end and transfer-end sequence, and checks the results against arithmetic expectations.

The corner cases it targets, and how a faulty design would show up:
- **Same-cycle operand end and step.** A design that copies back the pre-step address leaves the visible register one beat short.
- **Rotate mode.** A design that decodes the wrong mode code overwrites the start address in rotate mode.
- **Reload versus copy-back.** A design that lets copy-back beat reload shows the working address where the reload value belongs.
- **Rejected writes.** The bench sweeps every partial byte-enable pattern and every low-address pattern for both beat sizes. A flawed filter would either corrupt the register or raise the wrong flag.

// File: rtl/dsat_pkg.sv
package dsat_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned MODE_W    = 3;
    localparam logic [2:0]  ROT_CODE  = 3'b011;

    typedef struct packed {
        logic err_busy;
        logic err_align;
    } wr_flags_t;

    typedef struct packed {
        logic [ADDR_W-1:0] work;
    } work_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] vis;
        logic [ADDR_W-1:0] rld;
    } vis_state_t;

endpackage

// File: rtl/dsat_wr_check.sv
module dsat_wr_check #(
    parameter int unsigned AW   = 32,
    parameter int unsigned BE_W = AW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [BE_W-1:0] wr_be,
    input  logic [AW-1:0]   wr_data,
    input  logic            active,
    input  logic            size32,
    output logic            accept,
    output logic            err_busy_o,
    output logic            err_align_o
);
    import dsat_pkg::*;

    wr_flags_t flags_d, flags_q;
    logic      full_w;
    logic      aligned;

    always_comb begin
        full_w   = wr_en && (&wr_be);
        aligned  = size32 ? (wr_data[1:0] == 2'b00) : (wr_data[0] == 1'b0);
        accept   = full_w && !active && aligned;
        flags_d.err_busy  = full_w && active;
        flags_d.err_align = full_w && !active && !aligned;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign err_busy_o  = flags_q.err_busy;
    assign err_align_o = flags_q.err_align;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_busy_o && err_align_o)); // R5
    AST_PARTIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(&wr_be)) |=> (!err_busy_o && !err_align_o)); // R3
    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wr_be) && active) |=> err_busy_o); // R4

endmodule

// File: rtl/dsat_work_unit.sv
module dsat_work_unit #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    input  logic          size32,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] work_o,
    output logic [AW-1:0] work_next_o
);
    import dsat_pkg::*;

    localparam logic [AW-1:0] INC16 = AW'(2);
    localparam logic [AW-1:0] INC32 = AW'(4);

    logic [AW-1:0] work_d, work_q;
    logic [AW-1:0] inc;

    always_comb begin
        inc    = size32 ? INC32 : INC16;
        work_d = work_q;
        if (start) begin
            work_d = load_val;
        end else if (step) begin
            work_d = work_q + inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else begin
            work_q <= work_d;
        end
    end

    assign work_o      = work_q;
    assign work_next_o = work_d;

    AST_START_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (work_q == $past(load_val))); // R6
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && size32) |=> (work_q == $past(work_q) + INC32)); // R7

endmodule

// File: rtl/dsat_visible_reg.sv
module dsat_visible_reg #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_accept,
    input  logic [AW-1:0] wr_data,
    input  logic          rld_wr_en,
    input  logic [AW-1:0] rld_wr_data,
    input  logic          op_end,
    input  logic          xfer_end,
    input  logic          reload_en,
    input  logic          rotate,
    input  logic [AW-1:0] wb_val,
    output logic [AW-1:0] vis_o
);
    import dsat_pkg::*;

    logic [AW-1:0] vis_d, vis_q;
    logic [AW-1:0] rld_d, rld_q;
    logic          do_reload;
    logic          do_wb;

    always_comb begin
        do_reload = xfer_end && reload_en;
        do_wb     = (op_end || xfer_end) && !rotate;
        vis_d     = vis_q;
        rld_d     = rld_q;
        if (do_reload) begin
            vis_d = rld_q;
        end else if (do_wb) begin
            vis_d = wb_val;
        end else if (wr_accept) begin
            vis_d = wr_data;
        end
        if (rld_wr_en) begin
            rld_d = rld_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q <= '0;
            rld_q <= '0;
        end else begin
            vis_q <= vis_d;
            rld_q <= rld_d;
        end
    end

    assign vis_o = vis_q;

    AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && reload_en) |=> (vis_q == $past(rld_q))); // R11
    AST_ROTATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && !(xfer_end && reload_en) && !wr_accept) |=> $stable(vis_q)); // R10
    AST_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_end || xfer_end) && !rotate && !(xfer_end && reload_en))
        |=> (vis_q == $past(wb_val))); // R8

endmodule

// File: rtl/dma_src_addr_tracker.sv
module dma_src_addr_tracker #(
    parameter int unsigned AW     = dsat_pkg::ADDR_W,
    parameter int unsigned MODE_W = dsat_pkg::MODE_W,
    parameter logic [2:0]  ROT    = dsat_pkg::ROT_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW/8-1:0]   wr_be,
    input  logic [AW-1:0]     wr_data,
    input  logic              rld_wr_en,
    input  logic [AW-1:0]     rld_wr_data,
    input  logic              busy,
    input  logic              xfer_en,
    input  logic              size32,
    input  logic [MODE_W-1:0] src_mode,
    input  logic              reload_en,
    input  logic              start,
    input  logic              step,
    input  logic              op_end,
    input  logic              xfer_end,
    output logic [AW-1:0]     work_addr,
    output logic [AW-1:0]     reg_rdata,
    output logic              err_busy,
    output logic              err_align
);
    localparam int unsigned BE_W = AW / 8;

    logic          active;
    logic          rotate;
    logic          wr_accept;
    logic [AW-1:0] work_next;

    assign active = busy && xfer_en;
    assign rotate = (src_mode == MODE_W'(ROT));

    dsat_wr_check #(.AW(AW), .BE_W(BE_W)) u_wr_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_be      (wr_be),
        .wr_data    (wr_data),
        .active     (active),
        .size32     (size32),
        .accept     (wr_accept),
        .err_busy_o (err_busy),
        .err_align_o(err_align)
    );

    dsat_work_unit #(.AW(AW)) u_work (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step       (step),
        .size32     (size32),
        .load_val   (reg_rdata),
        .work_o     (work_addr),
        .work_next_o(work_next)
    );

    dsat_visible_reg #(.AW(AW)) u_vis (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_accept  (wr_accept),
        .wr_data    (wr_data),
        .rld_wr_en  (rld_wr_en),
        .rld_wr_data(rld_wr_data),
        .op_end     (op_end),
        .xfer_end   (xfer_end),
        .reload_en  (reload_en),
        .rotate     (rotate),
        .wb_val     (work_next),
        .vis_o      (reg_rdata)
    );

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && active && !op_end && !xfer_end) |=> $stable(reg_rdata)); // R4

endmodule

// File: tb/tb_dma_src_addr_tracker.sv
module tb_dma_src_addr_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rld_wr_en, busy, xfer_en, size32, reload_en;
    logic        start, step, op_end, xfer_end;
    logic [3:0]  wr_be;
    logic [31:0] wr_data, rld_wr_data;
    logic [2:0]  src_mode;
    logic [31:0] work_addr, reg_rdata;
    logic        err_busy, err_align;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] e_reg, e_work, e_rld;

    always #2 clk = ~clk;

    dma_src_addr_tracker dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rld_wr_en(rld_wr_en), .rld_wr_data(rld_wr_data), .busy(busy), .xfer_en(xfer_en),
        .size32(size32), .src_mode(src_mode), .reload_en(reload_en), .start(start),
        .step(step), .op_end(op_end), .xfer_end(xfer_end), .work_addr(work_addr),
        .reg_rdata(reg_rdata), .err_busy(err_busy), .err_align(err_align)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_be = 4'h0; rld_wr_en = 0;
        start = 0; step = 0; op_end = 0; xfer_end = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic sw_write(input logic [31:0] d, input logic [3:0] be);
        wr_en = 1; wr_be = be; wr_data = d;
        tick();
    endtask

    function automatic logic [31:0] inc_of(input logic s);
        return s ? 32'd4 : 32'd2;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0; busy = 0; xfer_en = 0; size32 = 0; src_mode = 3'b000; reload_en = 0;
        wr_data = '0; rld_wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 work", work_addr, 32'h0);
        chk("R1 reg", reg_rdata, 32'h0);
        chk("R1 flags", {30'h0, err_busy, err_align}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {work_addr[0], reg_rdata[0], err_busy, err_align}, 32'h0);

        // R12 reload register, used below
        e_rld = 32'hC0DE_0A00;
        rld_wr_en = 1; rld_wr_data = e_rld;
        tick();

        // Main sweep over size, mode, reload enable
        for (int sz = 0; sz < 2; sz++) begin
            for (int md = 0; md < 8; md++) begin
                for (int rl = 0; rl < 2; rl++) begin
                    automatic logic rot = (md == 3);
                    automatic logic [31:0] base = 32'h1000_0000 * (md + 1) + 32'h100 * sz + 32'h20 * rl;
                    automatic int k = 1 + (md % 3);
                    size32 = sz[0]; src_mode = md[2:0]; reload_en = rl[0];
                    busy = 0; xfer_en = 0;
                    sw_write(base, 4'hF);
                    e_reg = base;
                    chk("R2 write", reg_rdata, e_reg);
                    busy = 1; xfer_en = 1;
                    start = 1; tick();
                    e_work = e_reg;
                    chk("R6 start copy", work_addr, e_work);
                    for (int i = 0; i < k; i++) begin
                        step = 1; tick();
                        e_work = e_work + inc_of(sz[0]);
                        chk("R7 step", work_addr, e_work);
                    end
                    step = 1; op_end = 1; tick();
                    e_work = e_work + inc_of(sz[0]);
                    if (!rot) e_reg = e_work;
                    chk(rot ? "R10 op_end hold" : "R8 op_end writeback", reg_rdata, e_reg);
                    chk("R7 step with op_end", work_addr, e_work);
                    step = 1; tick();
                    e_work = e_work + inc_of(sz[0]);
                    xfer_end = 1; tick();
                    if (rl != 0) e_reg = e_rld;
                    else if (!rot) e_reg = e_work;
                    chk(rl != 0 ? "R11 reload" : (rot ? "R10 xfer_end hold" : "R9 xfer_end writeback"),
                        reg_rdata, e_reg);
                    busy = 0; xfer_en = 0;
                end
            end
        end

        // Wrap at top of address space
        size32 = 1; src_mode = 0; reload_en = 0;
        sw_write(32'hFFFF_FFFC, 4'hF);
        start = 1; tick();
        step = 1; tick();
        chk("R7 wrap", work_addr, 32'h0);

        // R6: start wins over step
        sw_write(32'h0000_4440, 4'hF);
        start = 1; step = 1; tick();
        chk("R6 start over step", work_addr, 32'h0000_4440);
        e_reg = 32'h0000_4440;

        // R3: partial writes ignored
        for (int b = 0; b < 15; b++) begin
            sw_write(32'hDEAD_0000, b[3:0]);
            chk("R3 partial reg", reg_rdata, e_reg);
            chk("R3 partial flags", {30'h0, err_busy, err_align}, 32'h0);
        end

        // R4: write while active rejected; inactive combos accepted
        for (int c = 0; c < 4; c++) begin
            busy = c[0]; xfer_en = c[1];
            sw_write(32'h0000_8000 + 32'h10 * c, 4'hF);
            if (c == 3) begin
                chk("R4 busy flag", {31'h0, err_busy}, 32'h1);
                chk("R4 reg kept", reg_rdata, e_reg);
                @(negedge clk);
                chk("R4 one-cycle pulse", {31'h0, err_busy}, 32'h0);
            end else begin
                e_reg = 32'h0000_8000 + 32'h10 * c;
                chk("R2 inactive accept", reg_rdata, e_reg);
                chk("R4 no flag", {31'h0, err_busy}, 32'h0);
            end
        end
        busy = 0; xfer_en = 0;

        // R5: alignment sweep
        for (int s = 0; s < 2; s++) begin
            for (int lo = 0; lo < 4; lo++) begin
                automatic logic mis = s ? (lo != 0) : lo[0];
                automatic logic [31:0] d = 32'h0002_0000 + 32'h100 * s + lo;
                size32 = s[0];
                sw_write(d, 4'hF);
                if (!mis) e_reg = d;
                chk("R5 align flag", {31'h0, err_align}, {31'h0, mis});
                chk("R5 align reg", reg_rdata, e_reg);
                chk("R5 no busy flag", {31'h0, err_busy}, 32'h0);
            end
        end
        // R5: busy takes precedence over misalignment
        size32 = 1; busy = 1; xfer_en = 1;
        sw_write(32'h0000_0003, 4'hF);
        chk("R5 precedence", {30'h0, err_busy, err_align}, 32'h2);
        busy = 0; xfer_en = 0;

        // R13: boundary update beats simultaneous software write
        size32 = 0; src_mode = 0; reload_en = 0;
        sw_write(32'h0000_0100, 4'hF);
        start = 1; tick();
        step = 1; tick();
        wr_en = 1; wr_be = 4'hF; wr_data = 32'h0000_0900; op_end = 1; tick();
        chk("R13 writeback wins", reg_rdata, 32'h0000_0102);

        // R12: new reload value used at next transfer end
        rld_wr_en = 1; rld_wr_data = 32'h0000_7700; tick();
        reload_en = 1; xfer_end = 1; tick();
        chk("R12 new reload", reg_rdata, 32'h0000_7700);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule